// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves one branch instruction per clock. It receives a 32-bit instruction word together with the current program counter, the count register, the link register, the 32-bit condition register and a flag that selects full-width or 32-bit addressing. From these it works out whether the branch is taken and the next program counter. It also produces a new count value when the branch consumes the counter, and a new link value when the branch saves a return address.

All evaluation is combinational. The results go into one bank of output registers, so a word presented with `in_valid` in one cycle shows up on the `res_*` ports after the next rising edge. The surrounding pipeline owns the architectural registers. It applies `res_ctr` and `res_lr` only when the matching write-enable is high.

Three forms are recognised by the primary opcode in bits 31..26:
- 18: direct branch with a 24-bit word displacement.
- 16: conditional branch with a 14-bit word displacement.
- 19: conditional branch through a register, where the extended opcode in bits 10..1 must be 16 or 528.

Any other word passes through as a non-branch.

Top module: `brn_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output register is cleared, including `res_valid`, `res_npc` and both write-enables.
- R2: A word presented with `in_valid` high produces `res_valid` high after the next rising edge. A cycle with `in_valid` low produces `res_valid`, `res_ctr_we` and `res_lr_we` low.
- R3: Opcode 18 is always taken. Its displacement is bits 25..2 followed by two zero bits, sign-extended from bit 25. The target is pc plus the displacement when bit 1 is 0, and the displacement itself when bit 1 is 1.
- R4: For opcode 16, the displacement is bits 15..2 followed by two zero bits, sign-extended from bit 15. Bit 1 selects relative or absolute addressing exactly as in R3.
- R5: Let the option field be bits 25..21. For opcodes 16 and 19, when option bit 2 is 0, the counter is decremented, `res_ctr_we` is set and `res_ctr` is ctr-1. The counter test then passes only when (ctr-1 == 0) equals option bit 1. When option bit 2 is 1, the counter is neither changed nor tested.
- R6: For opcodes 16 and 19, when option bit 4 is 0, taking the branch also requires condition-register bit (31 - bits 20..16) to equal option bit 3. When option bit 4 is 1, the condition register is ignored. The branch is taken only when both the counter test and the condition test pass.
- R7: For opcode 19, bit 10 set selects the incoming count register as target, and bit 10 clear selects the incoming link register. The two low target bits are forced to 0. The target always uses the values before any decrement or link write.
- R8: On any recognised branch with bit 0 set, `res_lr_we` is 1 and `res_lr` is pc+4, whether or not the branch is taken.
- R9: A branch that is not taken gives `res_npc` = pc+4 and `res_taken` = 0.
- R10: With `mode64` low, the target, the sequential address pc+4 and the saved link value all keep only their low 32 bits. The upper bits are zero.
- R11: A word that is not one of the three branch forms gives `res_is_br` = 0, `res_taken` = 0, `res_npc` = pc+4, and neither write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word and register values are valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| ctr | input | XLEN | Current count register |
| lr | input | XLEN | Current link register |
| cr | input | 32 | Current condition register |
| mode64 | input | 1 | 1: full-width addressing, 0: 32-bit addressing |
| res_valid | output | 1 | Result registers hold a resolved word |
| res_is_br | output | 1 | The word was a recognised branch |
| res_taken | output | 1 | The branch was taken |
| res_npc | output | XLEN | Next program counter |
| res_ctr_we | output | 1 | Count register is to be written |
| res_ctr | output | XLEN | New count value |
| res_lr_we | output | 1 | Link register is to be written |
| res_lr | output | XLEN | New link value |

## Verification
The assertions assume that `in_valid` stays low during reset. They also assume that pc, ctr and mode64 are the values that belonged to the word in the cycle it was presented, since several properties compare a result with `$past` of those inputs. The stimulus meets both conditions: it holds `in_valid` low through reset, and it changes every input only on the falling edge, together with `in_valid`, one word per cycle.

// File: rtl/brn_pkg.sv
// Package: shared opcode values and the branch-kind type used by the
// branch resolution unit and its sub-blocks.
package brn_pkg;

    localparam logic [5:0] OP_DIRECT   = 6'd18;
    localparam logic [5:0] OP_COND     = 6'd16;
    localparam logic [5:0] OP_REGFORM  = 6'd19;
    localparam logic [9:0] XO_VIA_LINK = 10'd16;
    localparam logic [9:0] XO_VIA_CNT  = 10'd528;

    typedef enum logic [1:0] {
        BK_NONE,
        BK_DIRECT,
        BK_COND_DISP,
        BK_COND_REG
    } brn_kind_e;

endpackage

// File: rtl/brn_decode.sv
// Decoder: classifies the instruction word and extracts the option field,
// condition-bit index, addressing/link flags, register-target select and
// the sign-extended displacement for the displacement forms.
// Assumes XLEN >= 32.
module brn_decode
    import brn_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]     instr,
    output brn_kind_e       kind,
    output logic [4:0]      opt,
    output logic [4:0]      bit_idx,
    output logic            absolute,
    output logic            link,
    output logic            via_cnt,
    output logic [XLEN-1:0] disp
);
    localparam int EXT_LONG  = XLEN - 26;
    localparam int EXT_SHORT = XLEN - 16;

    logic [5:0] opcode;
    logic [9:0] xo;

    assign opcode   = instr[31:26];
    assign xo       = instr[10:1];
    assign opt      = instr[25:21];
    assign bit_idx  = instr[20:16];
    assign absolute = instr[1];
    assign link     = instr[0];
    assign via_cnt  = instr[10];

    // Classify the word into one of the supported branch forms.
    always_comb begin
        kind = BK_NONE;
        if (opcode == OP_DIRECT)
            kind = BK_DIRECT;
        else if (opcode == OP_COND)
            kind = BK_COND_DISP;
        else if (opcode == OP_REGFORM && (xo == XO_VIA_LINK || xo == XO_VIA_CNT))
            kind = BK_COND_REG;
    end

    // Pick and sign-extend the displacement for the form in use.
    always_comb begin
        if (kind == BK_DIRECT)
            disp = {{EXT_LONG{instr[25]}}, instr[25:2], 2'b00};
        else
            disp = {{EXT_SHORT{instr[15]}}, instr[15:2], 2'b00};
    end

endmodule

// File: rtl/brn_cond.sv
// Condition evaluator: applies the optional counter decrement and test and
// the optional condition-register bit test, and yields the taken decision.
// Assumes the condition register is 32 bits with bit 0 as the most
// significant condition bit.
module brn_cond
    import brn_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  brn_kind_e       kind,
    input  logic [4:0]      opt,
    input  logic [4:0]      bit_idx,
    input  logic [31:0]     cr,
    input  logic [XLEN-1:0] ctr,
    output logic [XLEN-1:0] ctr_dec,
    output logic            ctr_we,
    output logic            taken
);
    logic is_cond;
    logic cnt_pass;
    logic cr_pass;
    logic [4:0] cr_pos;

    assign is_cond = (kind == BK_COND_DISP) || (kind == BK_COND_REG);
    assign ctr_dec = ctr - XLEN'(1);
    assign cr_pos  = 5'd31 - bit_idx;

    // Counter test: decrement first, then compare the new value with zero.
    always_comb begin
        ctr_we   = is_cond && !opt[2];
        cnt_pass = 1'b1;
        if (!opt[2])
            cnt_pass = ((ctr_dec == '0) == opt[1]);
    end

    // Condition-bit test: selected bit must match the wanted polarity.
    always_comb begin
        cr_pass = 1'b1;
        if (!opt[4])
            cr_pass = (cr[cr_pos] == opt[3]);
    end

    // Combine the tests; direct branches are always taken.
    always_comb begin
        case (kind)
            BK_DIRECT:    taken = 1'b1;
            BK_COND_DISP,
            BK_COND_REG:  taken = cnt_pass && cr_pass;
            default:      taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/brn_target.sv
// Address generator: forms the branch target and the sequential address,
// truncating both to NARROW_W bits when full-width mode is off.
// Assumes NARROW_W < XLEN.
module brn_target
    import brn_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32
) (
    input  brn_kind_e       kind,
    input  logic            absolute,
    input  logic            via_cnt,
    input  logic [XLEN-1:0] disp,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] ctr,
    input  logic [XLEN-1:0] lr,
    input  logic            mode64,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] seq
);
    localparam logic [XLEN-1:0] NARROW_MASK = {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [XLEN-1:0] WORD_MASK   = ~XLEN'(3);

    logic [XLEN-1:0] keep;
    logic [XLEN-1:0] raw;

    assign keep = mode64 ? '1 : NARROW_MASK;
    assign seq  = (pc + XLEN'(4)) & keep;

    // Raw target: register source or displacement, relative or absolute.
    always_comb begin
        if (kind == BK_COND_REG)
            raw = (via_cnt ? ctr : lr) & WORD_MASK;
        else if (absolute)
            raw = disp;
        else
            raw = pc + disp;
    end

    // Truncate the target to the addressing mode in use.
    assign target = raw & keep;

endmodule

// File: rtl/brn_unit.sv
// Branch resolution unit top: decodes one branch word per cycle, evaluates
// its counter and condition tests, forms the next address and registers
// the results with one cycle of latency. Synchronous active-low reset.
module brn_unit
    import brn_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] ctr,
    input  logic [XLEN-1:0] lr,
    input  logic [31:0]     cr,
    input  logic            mode64,
    output logic            res_valid,
    output logic            res_is_br,
    output logic            res_taken,
    output logic [XLEN-1:0] res_npc,
    output logic            res_ctr_we,
    output logic [XLEN-1:0] res_ctr,
    output logic            res_lr_we,
    output logic [XLEN-1:0] res_lr
);
    brn_kind_e       kind;
    logic [4:0]      opt;
    logic [4:0]      bit_idx;
    logic            absolute;
    logic            link;
    logic            via_cnt;
    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] ctr_dec;
    logic            ctr_we;
    logic            taken;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] seq;
    logic            is_br;

    brn_decode #(.XLEN(XLEN)) u_dec (
        .instr    (instr),
        .kind     (kind),
        .opt      (opt),
        .bit_idx  (bit_idx),
        .absolute (absolute),
        .link     (link),
        .via_cnt  (via_cnt),
        .disp     (disp)
    );

    brn_cond #(.XLEN(XLEN)) u_cond (
        .kind    (kind),
        .opt     (opt),
        .bit_idx (bit_idx),
        .cr      (cr),
        .ctr     (ctr),
        .ctr_dec (ctr_dec),
        .ctr_we  (ctr_we),
        .taken   (taken)
    );

    brn_target #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_tgt (
        .kind     (kind),
        .absolute (absolute),
        .via_cnt  (via_cnt),
        .disp     (disp),
        .pc       (pc),
        .ctr      (ctr),
        .lr       (lr),
        .mode64   (mode64),
        .target   (target),
        .seq      (seq)
    );

    assign is_br = (kind != BK_NONE);

    // Result registers: capture one resolved word per valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_is_br  <= 1'b0;
            res_taken  <= 1'b0;
            res_npc    <= '0;
            res_ctr_we <= 1'b0;
            res_ctr    <= '0;
            res_lr_we  <= 1'b0;
            res_lr     <= '0;
        end else begin
            res_valid  <= in_valid;
            res_is_br  <= in_valid && is_br;
            res_taken  <= in_valid && taken;
            res_npc    <= taken ? target : seq;
            res_ctr_we <= in_valid && ctr_we;
            res_ctr    <= ctr_dec;
            res_lr_we  <= in_valid && is_br && link;
            res_lr     <= seq;
        end
    end

endmodule

// File: rtl/brn_unit_chk.sv
// Checker: temporal properties of the branch resolution unit's ports,
// attached to every instance of the top module by the bind below.
// Assumes in_valid is low while rst_n is low.
module brn_unit_chk #(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] ctr,
    input logic [XLEN-1:0] lr,
    input logic [31:0]     cr,
    input logic            mode64,
    input logic            res_valid,
    input logic            res_is_br,
    input logic            res_taken,
    input logic [XLEN-1:0] res_npc,
    input logic            res_ctr_we,
    input logic [XLEN-1:0] res_ctr,
    input logic            res_lr_we,
    input logic [XLEN-1:0] res_lr
);
    localparam logic [XLEN-1:0] LOW_MASK = {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    function automatic logic [XLEN-1:0] next_seq(input logic [XLEN-1:0] a, input logic m);
        return m ? (a + XLEN'(4)) : ((a + XLEN'(4)) & LOW_MASK);
    endfunction

    // An idle cycle leaves no result and no register write.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> (!res_valid && !res_ctr_we && !res_lr_we));

    // A valid word always yields a result on the next edge.
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |-> res_valid);

    // A direct branch is always taken.
    p_direct_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(instr[31:26]) == 6'd18) |-> res_taken);

    // A counter write carries the incoming counter minus one.
    p_ctr_minus_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_ctr_we) |-> (res_ctr == $past(ctr) - XLEN'(1)));

    // A link write carries the sequential address of the branch.
    p_link_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_lr_we) |-> (res_lr == next_seq($past(pc), $past(mode64))));

    // A fall-through goes to the sequential address.
    p_fall_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_valid && !res_taken) |-> (res_npc == next_seq($past(pc), $past(mode64))));

    // Narrow mode clears the upper address bits.
    p_narrow_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_valid && !$past(mode64)) |-> ((res_npc & ~LOW_MASK) == '0));

    // A non-branch word is never taken and writes nothing.
    p_nonbranch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_is_br) |-> (!res_taken && !res_ctr_we && !res_lr_we));

endmodule

bind brn_unit brn_unit_chk #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/sim_brn_unit.sv
`timescale 1ns/1ps
// Scoreboard bench for the branch resolution unit: the driver task computes
// the expected result from the requirements and queues it; the monitor pops
// and compares when a result appears.
module sim_brn_unit;
    localparam int XLEN = 64;

    typedef struct {
        string       tag;
        logic        is_br;
        logic        taken;
        logic [63:0] npc;
        logic        ctr_we;
        logic [63:0] ctr;
        logic        lr_we;
        logic [63:0] lr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] pc = '0, ctr = '0, lr = '0;
    logic [31:0] cr = '0;
    logic        mode64 = 1'b1;
    logic        res_valid, res_is_br, res_taken, res_ctr_we, res_lr_we;
    logic [63:0] res_npc, res_ctr, res_lr;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    brn_unit #(.XLEN(XLEN), .NARROW_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .pc(pc), .ctr(ctr), .lr(lr), .cr(cr), .mode64(mode64),
        .res_valid(res_valid), .res_is_br(res_is_br), .res_taken(res_taken),
        .res_npc(res_npc), .res_ctr_we(res_ctr_we), .res_ctr(res_ctr),
        .res_lr_we(res_lr_we), .res_lr(res_lr)
    );

    function automatic logic [31:0] w_direct(input logic [25:0] d, input logic aa, input logic lk);
        return {6'd18, d[25:2], aa, lk};
    endfunction
    function automatic logic [31:0] w_cond(input logic [4:0] bo, input logic [4:0] bi,
                                           input logic [15:0] d, input logic aa, input logic lk);
        return {6'd16, bo, bi, d[15:2], aa, lk};
    endfunction
    function automatic logic [31:0] w_reg(input logic [4:0] bo, input logic [4:0] bi,
                                          input logic to_cnt, input logic lk);
        return {6'd19, bo, bi, 5'd0, (to_cnt ? 10'd528 : 10'd16), lk};
    endfunction

    // Expected result written from R3..R11.
    function automatic exp_t predict(input string tag, input logic [31:0] w, input logic [63:0] p,
                                     input logic [63:0] c, input logic [63:0] l,
                                     input logic [31:0] crv, input logic m);
        exp_t e;
        logic [63:0] keep, nxt, tgt, d;
        logic [4:0] bo, bi;
        logic pass, cnd;
        keep = m ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        nxt  = (p + 64'd4) & keep;
        bo   = w[25:21];
        bi   = w[20:16];
        e.tag = tag; e.ctr = c; e.ctr_we = 1'b0; e.lr = nxt;
        pass = 1'b1; tgt = '0;
        cnd  = (w[31:26] == 6'd16) || (w[31:26] == 6'd19 && (w[10:1] == 10'd16 || w[10:1] == 10'd528));
        e.is_br = cnd || (w[31:26] == 6'd18);
        if (cnd) begin
            if (bo[2] == 1'b0) begin
                e.ctr = c - 64'd1; e.ctr_we = 1'b1;
                pass = (e.ctr == 64'd0) ? bo[1] : !bo[1];
            end
            if (bo[4] == 1'b0 && crv[31 - bi] != bo[3]) pass = 1'b0;
        end
        if (w[31:26] == 6'd18) begin
            d = {{38{w[25]}}, w[25:2], 2'b00};
            tgt = w[1] ? d : p + d;
        end else if (w[31:26] == 6'd16) begin
            d = {{48{w[15]}}, w[15:2], 2'b00};
            tgt = w[1] ? d : p + d;
        end else begin
            tgt = (w[10] ? c : l) & ~64'd3;
        end
        e.taken = e.is_br && pass;
        e.npc   = e.taken ? (tgt & keep) : nxt;
        e.lr_we = e.is_br && w[0];
        return e;
    endfunction

    // Driver: present one word on the falling edge and queue its expectation.
    task automatic send(input string tag, input logic [31:0] w, input logic [63:0] p,
                        input logic [63:0] c, input logic [63:0] l,
                        input logic [31:0] crv, input logic m);
        @(negedge clk);
        instr = w; pc = p; ctr = c; lr = l; cr = crv; mode64 = m; in_valid = 1'b1;
        sb.push_back(predict(tag, w, p, c, l, crv, m));
    endtask

    // Monitor: compare each result against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R2: unexpected result, npc=%h expected no result", res_npc);
            end else begin
                exp_t e;
                bit bad;
                e = sb.pop_front();
                n_checks++;
                bad = (res_is_br !== e.is_br) || (res_taken !== e.taken) || (res_npc !== e.npc)
                   || (res_ctr_we !== e.ctr_we) || (res_lr_we !== e.lr_we)
                   || (e.ctr_we && res_ctr !== e.ctr) || (e.lr_we && res_lr !== e.lr);
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: br=%b tk=%b npc=%h cwe=%b ctr=%h lwe=%b lr=%h expected br=%b tk=%b npc=%h cwe=%b ctr=%h lwe=%b lr=%h",
                             e.tag, res_is_br, res_taken, res_npc, res_ctr_we, res_ctr, res_lr_we, res_lr,
                             e.is_br, e.taken, e.npc, e.ctr_we, e.ctr, e.lr_we, e.lr);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 20000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs cleared while reset is held.
        n_checks++;
        if (res_valid !== 1'b0 || res_npc !== 64'd0 || res_ctr_we !== 1'b0 || res_lr_we !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: valid=%b npc=%h cwe=%b lwe=%b expected all zero",
                     res_valid, res_npc, res_ctr_we, res_lr_we);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 direct, relative and absolute; R8 link.
        send("R3 rel fwd",  w_direct(26'h40, 0, 0),       64'h1000, 0, 0, 0, 1);
        send("R3 rel back", w_direct(-26'sh100, 0, 0),    64'h2000, 0, 0, 0, 1);
        send("R3 abs R8",   w_direct(26'h80, 1, 1),       64'h2468, 0, 0, 0, 1);
        send("R3 wrap",     w_direct(26'h4, 0, 0),        64'hFFFF_FFFF_FFFF_FFFC, 0, 0, 0, 1);
        // R4 conditional displacement, always-true option.
        send("R4 rel back", w_cond(5'd20, 0, -16'sd8, 0, 0), 64'h3000, 7, 0, 0, 1);
        send("R4 abs",      w_cond(5'd20, 0, 16'h7FFC, 1, 0), 64'h3000, 7, 0, 0, 1);
        send("R4 abs neg",  w_cond(5'd20, 0, 16'h8000, 1, 0), 64'h3000, 7, 0, 0, 1);
        // R5 counter decrement and test.
        send("R5 nz taken", w_cond(5'd16, 0, 16'h20, 0, 0), 64'h4000, 5, 0, 0, 1);
        send("R5 R9 to zero", w_cond(5'd16, 0, 16'h20, 0, 0), 64'h4000, 1, 0, 0, 1);
        send("R5 z taken",  w_cond(5'd18, 0, 16'h20, 0, 0), 64'h4000, 1, 0, 0, 1);
        send("R5 wrap",     w_cond(5'd16, 0, 16'h20, 0, 0), 64'h4000, 0, 0, 0, 1);
        // R6 condition bit, both polarities, and combined with counter.
        send("R6 true hit", w_cond(5'd12, 5'd2, 16'h40, 0, 0), 64'h5000, 9, 0, 32'h2000_0000, 1);
        send("R6 R9 miss",  w_cond(5'd12, 5'd2, 16'h40, 0, 0), 64'h5000, 9, 0, 32'h0, 1);
        send("R6 false hit", w_cond(5'd4, 5'd0, 16'h40, 0, 0), 64'h5000, 9, 0, 32'h7FFF_FFFF, 1);
        send("R6 R5 both",  w_cond(5'd0, 5'd0, 16'h40, 0, 0), 64'h5000, 3, 0, 32'h8000_0000, 1);
        // R7 register targets.
        send("R7 via link", w_reg(5'd20, 0, 0, 0), 64'h6000, 8, 64'h4007, 0, 1);
        send("R7 via cnt R8", w_reg(5'd20, 0, 1, 1), 64'h6000, 64'h5002, 64'h9, 0, 1);
        send("R7 R5 old lr", w_reg(5'd16, 0, 0, 1), 64'h6100, 2, 64'h7000, 0, 1);
        // R10 narrow addressing.
        send("R10 target",  w_direct(26'h8, 0, 1),  64'h1_FFFF_FFFC, 0, 0, 0, 0);
        send("R10 R9 seq",  w_cond(5'd4, 0, 16'h40, 0, 1), 64'h1_FFFF_FFFC, 0, 0, 32'h8000_0000, 0);
        send("R10 cnt",     w_reg(5'd20, 0, 1, 0), 64'h8000, 64'hABCD_0000_1234_5677, 0, 0, 0);
        // R11 non-branch words.
        send("R11 other op", {6'd31, 26'h3FF_FFFF}, 64'h9000, 4, 4, 32'hFFFF_FFFF, 1);
        send("R11 bad xo",   {6'd19, 5'd20, 5'd0, 5'd0, 10'd150, 1'b1}, 64'h9000, 4, 4, 0, 1);

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R2: an idle cycle leaves no result and no writes.
        n_checks++;
        if (res_valid !== 1'b0 || res_ctr_we !== 1'b0 || res_lr_we !== 1'b0) begin
            n_fail++;
            $display("FAIL R2: idle valid=%b cwe=%b lwe=%b expected 0 0 0",
                     res_valid, res_ctr_we, res_lr_we);
        end
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule